// File: doc/BRIEF.md
# Posted Column Command Latency Sequencer

This block sits on the controller side of a double-data-rate memory interface. It accepts read and write column commands, each with an 11-bit starting column. For every accepted command it works out the clock in which the burst data phase begins. Reads use the sum of the additive and CAS latencies. Writes use one clock less. At that clock it opens a read-capture window or a write-drive window for as many clocks as the burst needs. During the window it reports the index of the first beat carried in each clock and the column that beat addresses.

Commands may be posted early, before the row-to-column delay has elapsed. They then wait in an internal delay line for the configured additive latency plus the CAS latency. The delay line holds one slot per clock of the largest latency, so bursts issued at the minimum command spacing give back-to-back windows with no gap. Commands that come too soon are dropped and flagged. Latency and burst settings are taken from the configuration pins only while nothing is in flight.

Top module: `posted_cas_seq`

## Requirements
- R1: An accepted read sampled at clock edge k raises `rd_capture` after edge k+AL+CL.
- R2: An accepted write sampled at edge k raises `wr_drive` after edge k+AL+CL-1.
- R3: A window lasts BL/2 clocks, two beats per clock. `beat_idx` is 0 in the first clock of a burst and rises by 2 each clock (0,2 for BL 4; 0,2,4,6 for BL 8).
- R4: `beat_col` keeps the column bits above the burst block and sets the low log2(BL) bits to (start low bits + `beat_idx`) modulo BL. This is a sequential wrap inside the aligned block.
- R5: With BL 4, a command sampled less than 2 edges after the last accepted command is dropped. `cmd_drop` is then high for the one clock after that edge, and the command produces no window.
- R6: With BL 8, a command sampled less than 4 edges after the last accepted command is dropped in the same way.
- R7: With BL 4, a write sampled less than 3 edges after an accepted read is dropped, so a 4-beat read is never cut short.
- R8: With BL 8, a write 4 edges after a read is accepted. Its window replaces the running read window from its own start clock.
- R9: Commands of one type spaced exactly the minimum spacing apart give contiguous windows with no idle clock between them.
- R10: AL, CL and BL are loaded only at an edge where no command is waiting, no window is open and `cmd_valid` is low. Commands always use the loaded values.
- R11: At an idle edge, inputs outside AL 0..5, CL 3..6 or BL in {4,8} set `cfg_bad` after that edge and leave the loaded settings unchanged. Legal inputs at an idle edge clear it.
- R12: After reset the outputs are low, the settings are AL 0, CL 3, BL 4, and `rd_capture` and `wr_drive` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_al | input | 3 | Additive latency setting |
| cfg_cl | input | 3 | CAS latency setting |
| cfg_bl | input | 4 | Burst length setting, 4 or 8 |
| cmd_valid | input | 1 | Column command present this clock |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_col | input | 11 | Starting column of the burst |
| rd_capture | output | 1 | Read data capture window |
| wr_drive | output | 1 | Write data drive window |
| beat_idx | output | 3 | Index of the first beat carried this clock |
| beat_col | output | 11 | Column addressed by that beat |
| cmd_drop | output | 1 | Command dropped for spacing, one clock |
| cfg_bad | output | 1 | Last configuration sampled was illegal |

## Verification
A slot that moves the wrong way in the delay line shows up as a window that opens one or more clocks early or late. It appears exactly AL+CL (or one less) clocks after the command, so every window edge is compared clock by clock. A stale spacing counter or read/write history shows within a single command as a wrong `cmd_drop` pulse or a missing or extra window. A wrong beat counter shows in the next clock of the burst as a bad `beat_idx` or `beat_col` value. Stale settings show as a shifted window on the first command after the change.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int COL_W  = 11;
    localparam int LAT_W  = 4;
    localparam int GAP_W  = 3;
    localparam logic [2:0] AL_MAX = 3'd5;
    localparam logic [2:0] CL_MIN = 3'd3;
    localparam logic [2:0] CL_MAX = 3'd6;
    localparam int RL_MAX = 11;

    typedef struct packed {
        logic [2:0] al;
        logic [2:0] cl;
        logic       bl8;
    } cfg_t;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [COL_W-1:0] col;
    } slot_t;

    function automatic logic cfg_ok(input logic [2:0] al, input logic [2:0] cl,
                                    input logic [3:0] bl);
        return (al <= AL_MAX) && (cl >= CL_MIN) && (cl <= CL_MAX) &&
               ((bl == 4'd4) || (bl == 4'd8));
    endfunction

    function automatic logic [LAT_W-1:0] read_lat(input cfg_t c);
        return {1'b0, c.al} + {1'b0, c.cl};
    endfunction

    function automatic logic [GAP_W-1:0] min_gap(input logic bl8);
        return bl8 ? 3'd4 : 3'd2;
    endfunction

    function automatic logic [COL_W-1:0] col_at_beat(input logic [COL_W-1:0] base,
                                                     input logic [2:0] beat,
                                                     input logic bl8);
        logic [COL_W-1:0] r;
        r = base;
        if (bl8) r[2:0] = base[2:0] + beat;
        else     r[1:0] = base[1:0] + beat[1:0];
        return r;
    endfunction

endpackage

// File: rtl/psq_cfg.sv
module psq_cfg
    import psq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idle,
    input  logic [2:0] al_in,
    input  logic [2:0] cl_in,
    input  logic [3:0] bl_in,
    output cfg_t       cfg,
    output logic       bad
);
    logic legal;
    assign legal = cfg_ok(al_in, cl_in, bl_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{al: 3'd0, cl: 3'd3, bl8: 1'b0};
            bad <= 1'b0;
        end else if (idle) begin
            bad <= !legal;
            if (legal) cfg <= '{al: al_in, cl: cl_in, bl8: (bl_in == 4'd8)};
        end
    end
endmodule

// File: rtl/psq_gate.sv
module psq_gate
    import psq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic cmd_wr,
    input  logic bl8,
    output logic accept,
    output logic drop
);
    localparam logic [GAP_W-1:0] SAT = '1;

    logic [GAP_W-1:0] since;
    logic             last_rd;
    logic             too_soon;

    always_comb begin
        too_soon = (since < min_gap(bl8)) ||
                   (!bl8 && last_rd && cmd_wr && (since < 3'd3));
        accept   = cmd_valid && !too_soon;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since   <= SAT;
            last_rd <= 1'b0;
            drop    <= 1'b0;
        end else begin
            drop <= cmd_valid && too_soon;
            if (accept) begin
                since   <= 3'd1;
                last_rd <= !cmd_wr;
            end else if (since != SAT) begin
                since <= since + 3'd1;
            end
        end
    end
endmodule

// File: rtl/psq_pipe.sv
module psq_pipe
    import psq_pkg::*;
#(
    parameter int DEPTH = RL_MAX
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LAT_W-1:0] lat,
    input  logic             wr,
    input  logic [COL_W-1:0] col,
    output slot_t            head,
    output logic             busy
);
    slot_t            slot [DEPTH];
    slot_t            entry;
    logic [LAT_W-1:0] pos;

    assign entry = '{vld: 1'b1, wr: wr, col: col};
    assign pos   = lat - 4'd1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_t nxt;
        if (i == DEPTH - 1) begin : g_last
            assign nxt = '0;
        end else begin : g_mid
            assign nxt = slot[i+1];
        end
        always_ff @(posedge clk) begin
            if (rst)                             slot[i] <= '0;
            else if (push && pos == LAT_W'(i))   slot[i] <= entry;
            else                                 slot[i] <= nxt;
        end
    end

    always_comb begin
        busy = 1'b0;
        for (int i = 0; i < DEPTH; i++) busy = busy | slot[i].vld;
    end

    assign head = slot[0];
endmodule

// File: rtl/psq_burst.sv
module psq_burst
    import psq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  slot_t            head,
    input  logic             bl8,
    output logic             rd_win,
    output logic             wr_win,
    output logic             active,
    output logic [2:0]       beat,
    output logic [COL_W-1:0] col_out
);
    logic             is_wr;
    logic [COL_W-1:0] base;
    logic [1:0]       cnt;
    logic             last;

    assign last = (cnt == (bl8 ? 2'd3 : 2'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            is_wr  <= 1'b0;
            base   <= '0;
            cnt    <= '0;
        end else if (head.vld) begin
            active <= 1'b1;
            is_wr  <= head.wr;
            base   <= head.col;
            cnt    <= '0;
        end else if (active) begin
            if (last) active <= 1'b0;
            else      cnt    <= cnt + 2'd1;
        end
    end

    assign rd_win  = active && !is_wr;
    assign wr_win  = active && is_wr;
    assign beat    = active ? {cnt, 1'b0} : 3'd0;
    assign col_out = active ? col_at_beat(base, {cnt, 1'b0}, bl8) : '0;
endmodule

// File: rtl/posted_cas_seq.sv
module posted_cas_seq
    import psq_pkg::*;
#(
    parameter int DEPTH = RL_MAX
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cfg_al,
    input  logic [2:0]       cfg_cl,
    input  logic [3:0]       cfg_bl,
    input  logic             cmd_valid,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    output logic             rd_capture,
    output logic             wr_drive,
    output logic [2:0]       beat_idx,
    output logic [COL_W-1:0] beat_col,
    output logic             cmd_drop,
    output logic             cfg_bad
);
    cfg_t             cur;
    logic             accept;
    logic             pipe_busy;
    logic             burst_act;
    logic             idle;
    logic [LAT_W-1:0] lat;
    slot_t            head;

    assign idle = !pipe_busy && !burst_act && !cmd_valid;
    assign lat  = cmd_wr ? read_lat(cur) - 4'd1 : read_lat(cur);

    psq_cfg u_cfg (
        .clk(clk), .rst(rst), .idle(idle),
        .al_in(cfg_al), .cl_in(cfg_cl), .bl_in(cfg_bl),
        .cfg(cur), .bad(cfg_bad)
    );

    psq_gate u_gate (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
        .bl8(cur.bl8), .accept(accept), .drop(cmd_drop)
    );

    psq_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst(rst), .push(accept), .lat(lat), .wr(cmd_wr),
        .col(cmd_col), .head(head), .busy(pipe_busy)
    );

    psq_burst u_burst (
        .clk(clk), .rst(rst), .head(head), .bl8(cur.bl8),
        .rd_win(rd_capture), .wr_win(wr_drive), .active(burst_act),
        .beat(beat_idx), .col_out(beat_col)
    );
endmodule

// File: rtl/psq_checker.sv
module psq_checker
    import psq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cfg_al,
    input logic [2:0] cfg_cl,
    input logic [3:0] cfg_bl,
    input logic       rd_capture,
    input logic       wr_drive,
    input logic [2:0] beat_idx,
    input logic       cmd_drop,
    input logic       cfg_bad
);
    logic win;
    assign win = rd_capture || wr_drive;

    assert_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(rd_capture && wr_drive));

    assert_beat_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(win) |-> beat_idx == 3'd0);

    assert_beat_step_R3: assert property (@(posedge clk) disable iff (rst)
        (win && $past(win) && beat_idx != 3'd0) |-> beat_idx == $past(beat_idx) + 3'd2);

    assert_drop_cause_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_drop |-> $past(cmd_valid));

    assert_cfg_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_bad) |-> $past(!cfg_ok(cfg_al, cfg_cl, cfg_bl)));
endmodule

bind posted_cas_seq psq_checker u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
    .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
    .rd_capture(rd_capture), .wr_drive(wr_drive), .beat_idx(beat_idx),
    .cmd_drop(cmd_drop), .cfg_bad(cfg_bad)
);

// File: tb/tb_posted_cas_seq.sv
module tb_posted_cas_seq;
    localparam int N = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_al = 3'd0;
    logic [2:0]  cfg_cl = 3'd3;
    logic [3:0]  cfg_bl = 4'd4;
    logic        cmd_valid = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [10:0] cmd_col = '0;
    logic        rd_capture, wr_drive, cmd_drop, cfg_bad;
    logic [2:0]  beat_idx;
    logic [10:0] beat_col;

    always #10 clk = ~clk;

    posted_cas_seq dut (
        .clk(clk), .rst(rst), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
        .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_col(cmd_col),
        .rd_capture(rd_capture), .wr_drive(wr_drive), .beat_idx(beat_idx),
        .beat_col(beat_col), .cmd_drop(cmd_drop), .cfg_bad(cfg_bad)
    );

    int nchk = 0, nfail = 0, n = 0;
    bit done = 0;
    string ph = "RND";

    bit          exp_rd [N];
    bit          exp_wr [N];
    bit          exp_drop [N];
    bit          exp_bad [N];
    int          exp_beat [N];
    logic [10:0] exp_col [N];

    int   m_al = 0, m_cl = 3;
    bit   m_bl8 = 0, m_bad = 0, last_rd = 0;
    int   last_acc = -100, last_busy = -100;

    function automatic logic [10:0] colf(logic [10:0] c, int beat, bit bl8);
        logic [10:0] r = c;
        if (bl8) r[2:0] = 3'((int'(c[2:0]) + beat) % 8);
        else     r[1:0] = 2'((int'(c[1:0]) + beat) % 4);
        return r;
    endfunction

    task automatic cmp(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s/%s edge %0d actual=%0d expected=%0d", ph, tag, n, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    task automatic model(int e, bit v, bit w, logic [10:0] c);
        if (v) begin
            int  gap = e - last_acc;
            bit  viol = (gap < (m_bl8 ? 4 : 2)) || (!m_bl8 && last_rd && w && gap < 3);
            if (viol) begin
                if (e < N) exp_drop[e] = 1;
            end else begin
                int start = e + m_al + m_cl - (w ? 1 : 0);
                int len = m_bl8 ? 4 : 2;
                for (int k = 0; k < len; k++) begin
                    int idx = start + k;
                    if (idx < N) begin
                        exp_rd[idx] = !w; exp_wr[idx] = w;
                        exp_beat[idx] = 2 * k; exp_col[idx] = colf(c, 2 * k, m_bl8);
                    end
                end
                if (start + len - 1 > last_busy) last_busy = start + len - 1;
                last_acc = e; last_rd = !w;
            end
        end else if (e - 1 > last_busy) begin
            bit legal = (cfg_al <= 5) && (cfg_cl >= 3) && (cfg_cl <= 6) &&
                        (cfg_bl == 4 || cfg_bl == 8);
            m_bad = !legal;
            if (legal) begin m_al = cfg_al; m_cl = cfg_cl; m_bl8 = (cfg_bl == 8); end
        end
        if (e < N) exp_bad[e] = m_bad;
    endtask

    task automatic check_now();
        if (n >= N) return;
        cmp("R1 read window", rd_capture, exp_rd[n]);
        cmp("R2 write window", wr_drive, exp_wr[n]);
        cmp("R12 exclusive", rd_capture && wr_drive, 0);
        if (exp_rd[n] || exp_wr[n]) begin
            cmp("R3 beat index", beat_idx, exp_beat[n]);
            cmp("R4 beat column", beat_col, exp_col[n]);
        end
        cmp("R5 drop flag", cmd_drop, exp_drop[n]);
        cmp("R11 config error", cfg_bad, exp_bad[n]);
    endtask

    task automatic step(bit v, bit w, logic [10:0] c);
        cmd_valid = v; cmd_wr = w; cmd_col = c;
        model(n + 1, v, w, c);
        @(posedge clk);
        n++;
        @(negedge clk);
        check_now();
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) step(0, 0, '0);
    endtask

    task automatic set_cfg(int al, int cl, int bl);
        idle(16);
        cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl = 4'(bl);
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        ph = "R12 reset";
        cmp("R12 rd low", rd_capture, 0);
        cmp("R12 wr low", wr_drive, 0);
        cmp("R12 drop low", cmd_drop, 0);
        cmp("R12 cfg_bad low", cfg_bad, 0);

        // R1 R12: default settings AL0 CL3 used right after reset
        ph = "R12 default";
        step(1, 0, 11'h015); idle(8);

        // R9: gapless windows at the minimum spacing
        ph = "R9 BL4";
        step(1, 0, 11'h001); step(0, 0, '0); step(1, 0, 11'h006);
        step(0, 0, '0); step(1, 0, 11'h00B); idle(8);
        set_cfg(1, 4, 8);
        ph = "R9 BL8";
        step(1, 1, 11'h105); idle(3); step(1, 1, 11'h10A); idle(12);

        // R5: BL4 spacing too short
        set_cfg(0, 3, 4);
        ph = "R5 gap1";
        step(1, 0, 11'h020); step(1, 0, 11'h021); idle(8);
        // R7: BL4 read then write
        ph = "R7 gap2";
        step(1, 0, 11'h030); step(0, 0, '0); step(1, 1, 11'h031); idle(8);
        ph = "R7 gap3";
        step(1, 0, 11'h032); idle(2); step(1, 1, 11'h033); idle(8);

        // R6 R8: BL8 spacing and interruption
        set_cfg(2, 3, 8);
        ph = "R6 gap3";
        step(1, 0, 11'h040); idle(2); step(1, 0, 11'h041); idle(12);
        ph = "R8 interrupt";
        step(1, 0, 11'h047); idle(3); step(1, 1, 11'h04C); idle(12);

        // R1 R2: AL2 CL3 gives 5 and 4
        set_cfg(2, 3, 4);
        ph = "R2 post";
        step(1, 0, 11'h050); idle(3); step(1, 1, 11'h051); idle(8);

        // R10: settings change while a command is in flight
        ph = "R10 busy";
        step(1, 0, 11'h060);
        cfg_al = 3'd5;
        step(1, 0, 11'h061); idle(2);
        step(1, 1, 11'h062); idle(12);
        ph = "R10 loaded";
        step(1, 0, 11'h063); idle(14);

        // R11: illegal settings
        ph = "R11 al";
        set_cfg(6, 3, 4); step(1, 0, 11'h070); idle(10);
        ph = "R11 cl";
        set_cfg(0, 2, 4);
        ph = "R11 bl";
        set_cfg(0, 3, 5);
        ph = "R11 clear";
        set_cfg(0, 3, 4); step(1, 0, 11'h071); idle(6);

        // constrained random
        for (int cfgi = 0; cfgi < 4; cfgi++) begin
            int al = (cfgi == 3) ? 5 : cfgi;
            int cl = 3 + cfgi;
            set_cfg(al, cl, (cfgi % 2) ? 8 : 4);
            ph = "RND";
            for (int i = 0; i < 200; i++) begin
                bit v = ($urandom % 3) == 0;
                step(v, $urandom % 2, 11'($urandom));
            end
            idle(16);
        end

        report();
    end
endmodule